// File: doc/BRIEF.md
# Asynchronous Serial Frame Engine

This block is one full-duplex asynchronous serial channel. Both directions advance on an external oversampling tick, and each bit lasts a fixed number of ticks (16 by default). Software sets the frame format through a configuration word. The format covers a word length of 8 or 7 bits, an optional parity bit with selectable sense, and one or two stop bits. Characters are sent by writing a one-character transmit holding register. Received characters are collected from a one-character receive buffer.

Error reporting is split from configuration. Frame, parity and overrun errors are latched into sticky flags, and each kind is recorded only while its own enable bit in the configuration word is set. A flag clears only when a separate write-one command port names it. The receiver enable can only be turned on, and only through that same command port. Rewriting the configuration therefore never clears or sets errors and never touches the receiver enable. Level outputs report an empty transmit holding register, a waiting received character, and any latched error.

Top module: `serial_frame_engine`

## Requirements
- R1: Configuration bits [1:0] select the frame mode: 0 = 8 data bits without parity, 1 = 8 data bits plus parity, 2 = 7 data bits plus parity, 3 = same as 0.
- R2: Configuration bit [2] selects the transmitted stop bits: 0 gives one and 1 gives two. The receiver checks only the first stop bit, and a low level there is a frame error.
- R3: Configuration bit [3] sets the parity sense, with 1 = odd and 0 = even. The parity bit follows the last data bit.
- R4: The serial output idles high. A frame is a low start bit followed by the data bits LSB first, and each bit lasts 16 ticks. `tx_empty` is low while a written character waits and returns high when the shifter takes it.
- R5: The frame, parity and overrun flags are sticky. They clear only on a command write with bit [1], [2] or [3] set, respectively. Configuration writes leave them unchanged.
- R6: The receiver ignores the line until a command write with bit [0] set. After that, `rx_en` stays high until reset.
- R7: In mode 2, `rx_data[7]` reads as 0.
- R8: A transmit write while a character is still pending sets the overrun flag. The pending character is kept and is the one sent.
- R9: If a received character completes while `rx_avail` is high and no read is made, the overrun flag is set. The new character is discarded.
- R10: Frame errors are recorded only when configuration bit [4] is set, parity errors only when bit [5] is set, and overruns only when bit [6] is set. A received character is stored whether or not an error is recorded.
- R11: The line is sampled once at tick 8 of a start bit. If it is high there, the start is rejected: no character is produced and no error is recorded.
- R12: `err_any` is high exactly when at least one error flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_16x | input | 1 | Oversampling tick, 16 per bit |
| ctl_wr | input | 1 | Configuration write strobe |
| ctl_wdata | input | 7 | Configuration word |
| cmd_wr | input | 1 | Command write strobe |
| cmd_wdata | input | 4 | Command bits: [0] enable receiver, [1] clear frame, [2] clear parity, [3] clear overrun |
| tx_wr | input | 1 | Transmit holding register write strobe |
| tx_wdata | input | 8 | Character to send |
| rx_rd | input | 1 | Receive buffer read acknowledge |
| rxd | input | 1 | Serial input |
| txd | output | 1 | Serial output |
| tx_empty | output | 1 | Transmit holding register empty |
| rx_avail | output | 1 | Received character waiting |
| rx_data | output | 8 | Received character, masked to the word length |
| rx_en | output | 1 | Receiver enabled |
| frame_err | output | 1 | Sticky frame error |
| parity_err | output | 1 | Sticky parity error |
| overrun_err | output | 1 | Sticky overrun error |
| err_any | output | 1 | OR of the error flags |

## Verification
The transmit overrun is the hardest case to reach from the ports. It needs a character already in the shifter, a second one pending, and a third write while the second still waits. The bench spaces its writes so that the first character is loaded before the second arrives, then makes the third write inside the first frame's bit time. It then waits for `tx_empty` to rise and decodes the next frame to confirm that the second character survived. A receive overrun is reached by sending two whole frames without a read. Start-bit rejection is reached by a pulse on the line that ends before the mid-bit sample.

// File: rtl/sfe_pkg.sv
// Shared types for the serial frame engine: frame mode encoding, the
// configuration word layout and small mode-decoding helpers.
package sfe_pkg;

    typedef enum logic [1:0] {
        FM_8N  = 2'd0,
        FM_8P  = 2'd1,
        FM_7P  = 2'd2,
        FM_RSV = 2'd3
    } fmode_e;

    // Configuration word; mode occupies bits [1:0].
    typedef struct packed {
        logic   oe_en;
        logic   pe_en;
        logic   fe_en;
        logic   odd;
        logic   two_stop;
        fmode_e mode;
    } cfg_t;

    function automatic logic has_parity(fmode_e m);
        return (m == FM_8P) || (m == FM_7P);
    endfunction

    function automatic logic short_word(fmode_e m);
        return m == FM_7P;
    endfunction

endpackage

// File: rtl/sfe_tx.sv
// Transmit shifter. Builds a complete frame (start, data LSB first,
// optional parity, stop bits) on load and shifts it out one bit per
// OVS ticks. Assumes load is only pulsed while busy is low.
module sfe_tx #(
    parameter int DATA_W = 8,
    parameter int OVS    = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick,
    input  logic                 load,
    input  logic [DATA_W-1:0]    data,
    input  sfe_pkg::cfg_t        cfg,
    output logic                 busy,
    output logic                 txd
);
    import sfe_pkg::*;

    localparam int FRAME_W = DATA_W + 4;
    localparam int CW      = $clog2(FRAME_W + 1);
    localparam int TW      = $clog2(OVS);

    logic [FRAME_W-1:0] frame, shreg;
    logic [CW-1:0]      flen, dbits, left;
    logic [TW-1:0]      tcnt;
    logic               pbit;

    // Assemble the frame image and its length from the current configuration.
    always_comb begin
        dbits = short_word(cfg.mode) ? CW'(DATA_W - 1) : CW'(DATA_W);
        pbit  = cfg.odd;
        frame = '1;
        frame[0] = 1'b0;
        for (int i = 0; i < DATA_W; i++) begin
            if (i < int'(dbits)) begin
                frame[i + 1] = data[i];
                pbit         = pbit ^ data[i];
            end
        end
        if (has_parity(cfg.mode)) frame[int'(dbits) + 1] = pbit;
        flen = CW'(2) + dbits + CW'(has_parity(cfg.mode)) + CW'(cfg.two_stop);
    end

    // Load the frame and shift it out, one bit every OVS ticks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg <= '1;
            left  <= '0;
            tcnt  <= '0;
            busy  <= 1'b0;
        end else if (load) begin
            shreg <= frame;
            left  <= flen;
            tcnt  <= '0;
            busy  <= 1'b1;
        end else if (busy && tick) begin
            if (tcnt == TW'(OVS - 1)) begin
                tcnt  <= '0;
                shreg <= {1'b1, shreg[FRAME_W-1:1]};
                left  <= left - CW'(1);
                if (left == CW'(1)) busy <= 1'b0;
            end else begin
                tcnt <= tcnt + TW'(1);
            end
        end
    end

    assign txd = busy ? shreg[0] : 1'b1;

endmodule

// File: rtl/sfe_rx.sv
// Receive engine. Synchronises the line, qualifies a start bit at its
// middle tick, samples data and parity at bit centres and checks the
// first stop bit. Pulses done for one clock per completed frame.
module sfe_rx #(
    parameter int DATA_W = 8,
    parameter int OVS    = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick,
    input  logic                 enable,
    input  logic                 rxd,
    input  sfe_pkg::cfg_t        cfg,
    output logic                 done,
    output logic [DATA_W-1:0]    data,
    output logic                 frame_bad,
    output logic                 parity_bad
);
    import sfe_pkg::*;

    localparam int IW   = $clog2(DATA_W + 2);
    localparam int DIW  = $clog2(DATA_W);
    localparam int TW   = $clog2(OVS);
    localparam int HALF = OVS / 2;

    typedef enum logic [1:0] {RS_IDLE, RS_START, RS_DATA, RS_STOP} rstate_e;

    rstate_e         st;
    logic [1:0]      sync;
    logic            rx_s;
    logic [TW-1:0]   tcnt;
    logic [IW-1:0]   idx, dbits, nbits;
    logic            par_q, stop_q;

    // Two-stage synchroniser for the asynchronous line.
    always_ff @(posedge clk) begin
        if (!rst_n) sync <= 2'b11;
        else        sync <= {sync[0], rxd};
    end
    assign rx_s = sync[1];

    assign dbits = short_word(cfg.mode) ? IW'(DATA_W - 1) : IW'(DATA_W);
    assign nbits = dbits + IW'(has_parity(cfg.mode));

    // Frame reception state machine.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= RS_IDLE;
            tcnt   <= '0;
            idx    <= '0;
            data   <= '0;
            par_q  <= 1'b0;
            stop_q <= 1'b1;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            if (!enable) begin
                st <= RS_IDLE;
            end else if (tick) begin
                case (st)
                    RS_IDLE: if (!rx_s) begin
                        st   <= RS_START;
                        tcnt <= '0;
                    end
                    RS_START: if (tcnt == TW'(HALF - 1)) begin
                        tcnt <= '0;
                        idx  <= '0;
                        data <= '0;
                        st   <= rx_s ? RS_IDLE : RS_DATA;
                    end else begin
                        tcnt <= tcnt + TW'(1);
                    end
                    RS_DATA: if (tcnt == TW'(OVS - 1)) begin
                        tcnt <= '0;
                        if (idx < dbits) data[idx[DIW-1:0]] <= rx_s;
                        else             par_q <= rx_s;
                        if (idx == nbits - IW'(1)) st <= RS_STOP;
                        idx <= idx + IW'(1);
                    end else begin
                        tcnt <= tcnt + TW'(1);
                    end
                    default: if (tcnt == TW'(OVS - 1)) begin
                        tcnt   <= '0;
                        stop_q <= rx_s;
                        done   <= 1'b1;
                        st     <= RS_IDLE;
                    end else begin
                        tcnt <= tcnt + TW'(1);
                    end
                endcase
            end
        end
    end

    assign frame_bad  = !stop_q;
    assign parity_bad = has_parity(cfg.mode) && (par_q != ((^data) ^ cfg.odd));

endmodule

// File: rtl/serial_frame_engine.sv
// Top of the serial frame engine. Holds the configuration word, the
// receiver enable, the transmit holding register, the receive buffer and
// the sticky error flags. Flags and the receiver enable change only
// through the command port. Assumes tick_16x is a single-cycle strobe.
module serial_frame_engine #(
    parameter int DATA_W = 8,
    parameter int OVS    = 16,
    parameter int CFG_W  = 7,
    parameter int CMD_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_16x,
    input  logic              ctl_wr,
    input  logic [CFG_W-1:0]  ctl_wdata,
    input  logic              cmd_wr,
    input  logic [CMD_W-1:0]  cmd_wdata,
    input  logic              tx_wr,
    input  logic [DATA_W-1:0] tx_wdata,
    input  logic              rx_rd,
    input  logic              rxd,
    output logic              txd,
    output logic              tx_empty,
    output logic              rx_avail,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_en,
    output logic              frame_err,
    output logic              parity_err,
    output logic              overrun_err,
    output logic              err_any
);
    import sfe_pkg::*;

    cfg_t              ctl_q;
    logic [DATA_W-1:0] tx_hold, rx_buf, rx_word, rx_mask;
    logic              tx_pend, tx_busy, tx_load;
    logic              rx_done, rx_fbad, rx_pbad, rx_take;
    logic              clr_fe, clr_pe, clr_oe, ovr_evt;

    // Configuration register; touches nothing else.
    always_ff @(posedge clk) begin
        if (!rst_n)      ctl_q <= '0;
        else if (ctl_wr) ctl_q <= cfg_t'(ctl_wdata);
    end

    assign clr_fe = cmd_wr && cmd_wdata[1];
    assign clr_pe = cmd_wr && cmd_wdata[2];
    assign clr_oe = cmd_wr && cmd_wdata[3];

    // Receiver enable: set only by command bit 0.
    always_ff @(posedge clk) begin
        if (!rst_n)                       rx_en <= 1'b0;
        else if (cmd_wr && cmd_wdata[0])  rx_en <= 1'b1;
    end

    // Transmit holding register and hand-off to the shifter.
    assign tx_load = tx_pend && !tx_busy;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_hold <= '0;
            tx_pend <= 1'b0;
        end else if (tx_wr && !tx_pend) begin
            tx_hold <= tx_wdata;
            tx_pend <= 1'b1;
        end else if (tx_load) begin
            tx_pend <= 1'b0;
        end
    end

    sfe_tx #(.DATA_W(DATA_W), .OVS(OVS)) u_tx (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick_16x),
        .load  (tx_load),
        .data  (tx_hold),
        .cfg   (ctl_q),
        .busy  (tx_busy),
        .txd   (txd)
    );

    sfe_rx #(.DATA_W(DATA_W), .OVS(OVS)) u_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick_16x),
        .enable     (rx_en),
        .rxd        (rxd),
        .cfg        (ctl_q),
        .done       (rx_done),
        .data       (rx_word),
        .frame_bad  (rx_fbad),
        .parity_bad (rx_pbad)
    );

    // Receive buffer: a new character is kept only if the buffer is free.
    assign rx_take = rx_done && (!rx_avail || rx_rd);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_buf   <= '0;
            rx_avail <= 1'b0;
        end else if (rx_take) begin
            rx_buf   <= rx_word;
            rx_avail <= 1'b1;
        end else if (rx_rd) begin
            rx_avail <= 1'b0;
        end
    end

    assign rx_mask = short_word(ctl_q.mode) ? {1'b0, {(DATA_W-1){1'b1}}} : '1;
    assign rx_data = rx_buf & rx_mask;

    // Sticky error flags: a new event wins over a clear in the same cycle.
    assign ovr_evt = (tx_wr && tx_pend) || (rx_done && rx_avail && !rx_rd);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame_err   <= 1'b0;
            parity_err  <= 1'b0;
            overrun_err <= 1'b0;
        end else begin
            frame_err   <= (frame_err && !clr_fe) || (rx_done && rx_fbad && ctl_q.fe_en);
            parity_err  <= (parity_err && !clr_pe) || (rx_done && rx_pbad && ctl_q.pe_en);
            overrun_err <= (overrun_err && !clr_oe) || (ovr_evt && ctl_q.oe_en);
        end
    end

    assign tx_empty = !tx_pend;
    assign err_any  = frame_err || parity_err || overrun_err;

endmodule

// File: rtl/sfe_checker.sv
// Property checker for the serial frame engine, bound to every instance.
// Assumes the same clock and synchronous reset as the design.
module sfe_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       cmd_wr,
    input logic [3:0] cmd_wdata,
    input logic       tx_wr,
    input logic       tx_empty,
    input logic       oe_en,
    input logic       rx_en,
    input logic       frame_err,
    input logic       parity_err,
    input logic       overrun_err
);
    AST_FE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        frame_err && !(cmd_wr && cmd_wdata[1]) |=> frame_err); // R5
    AST_PE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        parity_err && !(cmd_wr && cmd_wdata[2]) |=> parity_err); // R5
    AST_OE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        overrun_err && !(cmd_wr && cmd_wdata[3]) |=> overrun_err); // R5
    AST_RXEN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        rx_en |=> rx_en); // R6
    AST_TX_OVERRUN: assert property (@(posedge clk) disable iff (!rst_n)
        tx_wr && !tx_empty && oe_en |=> overrun_err && !tx_empty); // R8
endmodule

bind serial_frame_engine sfe_checker u_sfe_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_wr      (cmd_wr),
    .cmd_wdata   (cmd_wdata),
    .tx_wr       (tx_wr),
    .tx_empty    (tx_empty),
    .oe_en       (ctl_q.oe_en),
    .rx_en       (rx_en),
    .frame_err   (frame_err),
    .parity_err  (parity_err),
    .overrun_err (overrun_err)
);

// File: tb/serial_frame_engine_tb.sv
module serial_frame_engine_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_16x = 1'b1;
    logic       ctl_wr = 1'b0;
    logic [6:0] ctl_wdata = '0;
    logic       cmd_wr = 1'b0;
    logic [3:0] cmd_wdata = '0;
    logic       tx_wr = 1'b0;
    logic [7:0] tx_wdata = '0;
    logic       rx_rd = 1'b0;
    logic       rxd_drv = 1'b1;
    logic       loop_en = 1'b0;
    logic       rxd, txd, tx_empty, rx_avail, rx_en;
    logic       frame_err, parity_err, overrun_err, err_any;
    logic [7:0] rx_data;
    int         n_checks = 0;
    int         n_err = 0;
    bit         finished = 1'b0;

    always #2 clk = ~clk;
    assign rxd = loop_en ? txd : rxd_drv;

    serial_frame_engine dut_i (
        .clk(clk), .rst_n(rst_n), .tick_16x(tick_16x),
        .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
        .cmd_wr(cmd_wr), .cmd_wdata(cmd_wdata),
        .tx_wr(tx_wr), .tx_wdata(tx_wdata), .rx_rd(rx_rd), .rxd(rxd),
        .txd(txd), .tx_empty(tx_empty), .rx_avail(rx_avail), .rx_data(rx_data),
        .rx_en(rx_en), .frame_err(frame_err), .parity_err(parity_err),
        .overrun_err(overrun_err), .err_any(err_any)
    );

    // Vectors: {mode[1:0], two_stop, odd, data[7:0]}
    localparam logic [11:0] VEC [6] = '{
        {2'd0, 1'b0, 1'b0, 8'hA5},
        {2'd1, 1'b0, 1'b0, 8'h3C},
        {2'd1, 1'b1, 1'b1, 8'h81},
        {2'd2, 1'b0, 1'b1, 8'hFF},
        {2'd2, 1'b1, 1'b0, 8'h55},
        {2'd3, 1'b0, 1'b0, 8'h0F}
    };

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [11:0] mk_frame(logic [1:0] m, logic odd, logic [7:0] d, logic flip);
        logic [11:0] f = '1;
        int nd = (m == 2'd2) ? 7 : 8;
        logic p = odd;
        f[0] = 1'b0;
        for (int i = 0; i < nd; i++) begin
            f[1 + i] = d[i];
            p = p ^ d[i];
        end
        if (m == 2'd1 || m == 2'd2) f[1 + nd] = p ^ flip;
        return f;
    endfunction

    function automatic int mk_len(logic [1:0] m, logic two);
        int nd = (m == 2'd2) ? 7 : 8;
        int np = (m == 2'd1 || m == 2'd2) ? 1 : 0;
        return 2 + nd + np + int'(two);
    endfunction

    task automatic wr_ctl(logic [6:0] v);
        ctl_wr = 1'b1; ctl_wdata = v;
        @(negedge clk); ctl_wr = 1'b0;
    endtask

    task automatic wr_cmd(logic [3:0] v);
        cmd_wr = 1'b1; cmd_wdata = v;
        @(negedge clk); cmd_wr = 1'b0; cmd_wdata = '0;
    endtask

    task automatic wr_tx(logic [7:0] v);
        tx_wr = 1'b1; tx_wdata = v;
        @(negedge clk); tx_wr = 1'b0;
    endtask

    task automatic rd_rx();
        rx_rd = 1'b1;
        @(negedge clk); rx_rd = 1'b0;
    endtask

    task automatic drive_frame(logic [1:0] m, logic two, logic odd, logic [7:0] d,
                               logic flip, logic bad_stop);
        logic [11:0] f = mk_frame(m, odd, d, flip);
        int n = mk_len(m, two);
        if (bad_stop) f[n - 1 - int'(two)] = 1'b0;
        for (int i = 0; i < n; i++) begin
            rxd_drv = f[i];
            repeat (16) @(negedge clk);
        end
        rxd_drv = 1'b1;
        repeat (24) @(negedge clk);
    endtask

    task automatic capture(int n, output logic [11:0] got);
        int g = 0;
        got = '1;
        while (txd !== 1'b0 && g < 2000) begin
            @(negedge clk);
            g++;
        end
        repeat (8) @(negedge clk);
        got[0] = txd;
        for (int i = 1; i < n; i++) begin
            repeat (16) @(negedge clk);
            got[i] = txd;
        end
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_err++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
            $finish;
        end
    end

    initial begin : main
        logic [11:0] got;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // Reset state
        check("R4 reset txd", 32'(txd), 32'd1);
        check("R4 reset tx_empty", 32'(tx_empty), 32'd1);
        check("R12 reset err_any", 32'(err_any), 32'd0);
        check("R6 reset rx_en", 32'(rx_en), 32'd0);
        check("R9 reset rx_avail", 32'(rx_avail), 32'd0);

        // R6: receiver disabled ignores the line
        wr_ctl(7'b1110000);
        drive_frame(2'd0, 1'b0, 1'b0, 8'h5A, 1'b0, 1'b0);
        check("R6 disabled rx_avail", 32'(rx_avail), 32'd0);
        wr_cmd(4'b0001);
        check("R6 rx_en set", 32'(rx_en), 32'd1);

        // Vector table: transmit decode plus loopback receive (R1 R2 R3 R4 R7)
        loop_en = 1'b1;
        for (int v = 0; v < 6; v++) begin
            logic [1:0] m = VEC[v][11:10];
            logic two = VEC[v][9];
            logic odd = VEC[v][8];
            logic [7:0] d = VEC[v][7:0];
            wr_ctl({3'b111, odd, two, m});
            wr_tx(d);
            capture(mk_len(m, two), got);
            check("R1 R2 R3 R4 tx frame", 32'(got), 32'(mk_frame(m, odd, d, 1'b0)));
            repeat (24) @(negedge clk);
            check("R1 loopback rx_avail", 32'(rx_avail), 32'd1);
            check("R7 loopback rx_data", 32'(rx_data), 32'((m == 2'd2) ? (d & 8'h7F) : d));
            check("R12 loopback no error", 32'(err_any), 32'd0);
            rd_rx();
        end
        loop_en = 1'b0;

        // R10/R12: parity error recorded
        wr_ctl(7'b1110001);
        drive_frame(2'd1, 1'b0, 1'b0, 8'h33, 1'b1, 1'b0);
        check("R10 bad parity stored", 32'(rx_data), 32'h33);
        check("R10 parity_err", 32'(parity_err), 32'd1);
        check("R12 err_any", 32'(err_any), 32'd1);
        rd_rx();
        // R5: config write leaves flag, command clears it
        wr_ctl(7'b0000000);
        @(negedge clk);
        check("R5 ctl keeps parity_err", 32'(parity_err), 32'd1);
        wr_cmd(4'b0100);
        check("R5 cmd clears parity_err", 32'(parity_err), 32'd0);

        // R10: frame error not recorded when disabled, character still stored
        wr_ctl(7'b1100000);
        drive_frame(2'd0, 1'b0, 1'b0, 8'hC6, 1'b0, 1'b1);
        check("R10 fe disabled frame_err", 32'(frame_err), 32'd0);
        check("R10 fe disabled stored", 32'(rx_avail), 32'd1);
        rd_rx();
        // R2: bad first stop with enable gives frame error
        wr_ctl(7'b1110000);
        drive_frame(2'd0, 1'b0, 1'b0, 8'h9C, 1'b0, 1'b1);
        check("R2 frame_err", 32'(frame_err), 32'd1);
        rd_rx();
        wr_cmd(4'b0010);
        check("R5 cmd clears frame_err", 32'(frame_err), 32'd0);

        // R11: short low pulse rejected
        rxd_drv = 1'b0;
        repeat (3) @(negedge clk);
        rxd_drv = 1'b1;
        repeat (60) @(negedge clk);
        check("R11 glitch no char", 32'(rx_avail), 32'd0);
        check("R11 glitch no error", 32'(err_any), 32'd0);

        // R9: receive overrun
        drive_frame(2'd0, 1'b0, 1'b0, 8'h11, 1'b0, 1'b0);
        drive_frame(2'd0, 1'b0, 1'b0, 8'h22, 1'b0, 1'b0);
        check("R9 first kept", 32'(rx_data), 32'h11);
        check("R9 overrun_err", 32'(overrun_err), 32'd1);
        rd_rx();
        @(negedge clk);
        check("R9 new char discarded", 32'(rx_avail), 32'd0);
        wr_cmd(4'b1000);
        check("R5 cmd clears overrun_err", 32'(overrun_err), 32'd0);

        // R8: transmit overrun keeps pending character
        wr_tx(8'hC3);
        repeat (3) @(negedge clk);
        wr_tx(8'h96);
        check("R4 pending tx_empty low", 32'(tx_empty), 32'd0);
        repeat (2) @(negedge clk);
        wr_tx(8'h00);
        check("R8 tx overrun_err", 32'(overrun_err), 32'd1);
        while (!tx_empty) @(negedge clk);
        capture(mk_len(2'd0, 1'b0), got);
        check("R8 pending char sent", 32'(got), 32'(mk_frame(2'd0, 1'b0, 8'h96, 1'b0)));
        repeat (20) @(negedge clk);
        check("R4 idle high", 32'(txd), 32'd1);

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
        $finish;
    end

endmodule